// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block listens to an I2C bus as a target device. After each START it collects the first byte on rising SCL edges. It compares the upper seven bits with an address held in a local register. When the address hits and the block is enabled, it drives the acknowledge clock with a programmable value. It also latches a sticky match flag, emits a one-cycle request to drop master mode, and raises an interrupt when interrupts are permitted.

SCL and SDA arrive already synchronized to the system clock. The block drives the bus only through an open-drain pull-down enable for SDA. When the address misses, the block stays silent until the next START or STOP. After an acknowledged address, the block releases the line and takes no part in the data bytes that follow.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset the address register reads 00h. A write stores bits 6:0 of the written byte. Bit 7 of the register always reads 0, whatever value is written.
- R2: The first byte after a START (SDA falling while SCL is high) is sampled MSB first on SCL rising edges. Its bits 7:1 are compared with the stored address. Bit 0 (read/write direction) does not affect the comparison.
- R3: On a hit, sda_pull equals the inverse of ack_bit from the SCL falling edge after the eighth bit until the next SCL falling edge. So ack_bit=0 pulls SDA low and ack_bit=1 leaves it released.
- R4: A hit sets match_flag. The flag stays at 1 until a cycle with match_clr high clears it.
- R5: Each hit produces exactly one mst_clr pulse, one clock long. A miss produces none.
- R6: irq is 1 exactly when match_flag is 1 and irq_en is 1.
- R7: While en is 0, no hit is detected, sda_pull stays 0, and neither match_flag nor mst_clr is raised.
- R8: On a miss, sda_pull stays 0 for the acknowledge clock and all following bits. A repeated START carrying the right address is then acknowledged normally.
- R9: A STOP in the middle of the address byte abandons it. Bits clocked afterwards without a new START cause no hit.
- R10: After the acknowledge clock of a hit, sda_pull returns to 0 and stays 0 during the following data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Module enable |
| addr_wr_en | input | 1 | Write strobe for the address register |
| addr_wr_data | input | 8 | Write data for the address register |
| addr_rd | output | 8 | Address register readback, bit 7 forced to 0 |
| ack_bit | input | 1 | Value placed on SDA during the acknowledge clock of a hit |
| irq_en | input | 1 | Interrupt enable |
| match_clr | input | 1 | Write-one-to-clear for the match flag |
| scl_i | input | 1 | Synchronized SCL |
| sda_i | input | 1 | Synchronized SDA |
| sda_pull | output | 1 | SDA pull-down enable (1 drives SDA low) |
| match_flag | output | 1 | Sticky address-match flag |
| mst_clr | output | 1 | One-cycle request to clear master mode |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the cycle-level invariants:
- a register write reads back with bit 7 at 0;
- mst_clr lasts one cycle and is followed by a set flag;
- the flag holds until cleared;
- irq never appears without irq_en;
- the pull-down starts only while SCL is low;
- disabling the block silences its outputs on the next cycle.

Only the bench scenarios can show whether a given byte should hit. They cover the acknowledge value across the whole slot, the read/write bit being ignored, the silence after a miss, and recovery on a repeated START. They also cover abandoning a byte at STOP and the quiet data phase after a hit.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = ADDR_W + 1;
    localparam int REG_W  = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_WAIT,
        ST_ACK_DRV,
        ST_IGNORE
    } am_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [ADDR_W-1:0] got,
                                      input logic [ADDR_W-1:0] own);
        return got == own;
    endfunction

endpackage

// File: rtl/i2c_am_cond.sv
module i2c_am_cond
    import i2c_am_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev.start = scl_q & scl_i & sda_q & ~sda_i;
        ev.stop  = scl_q & scl_i & ~sda_q & sda_i;
        ev.rise  = ~scl_q & scl_i;
        ev.fall  = scl_q & ~scl_i;
        ev.sda   = sda_i;
    end
endmodule

// File: rtl/i2c_am_areg.sv
module i2c_am_areg
    import i2c_am_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [ADDR_W-1:0] own_addr,
    output logic [REG_W-1:0]  rd_data
);
    localparam int PAD_W = REG_W - ADDR_W;

    always_ff @(posedge clk) begin
        if (rst)
            own_addr <= '0;
        else if (wr_en)
            own_addr <= wr_data[ADDR_W-1:0];
    end

    assign rd_data = {{PAD_W{1'b0}}, own_addr};
endmodule

// File: rtl/i2c_am_fsm.sv
module i2c_am_fsm
    import i2c_am_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  bus_ev_t           ev,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ack_bit,
    output logic              pull,
    output logic              hit
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    am_state_t         st;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            sh   <= '0;
            pull <= 1'b0;
            hit  <= 1'b0;
        end else begin
            hit <= 1'b0;
            if (ev.start) begin
                st   <= ST_ADDR;
                cnt  <= '0;
                pull <= 1'b0;
            end else if (ev.stop) begin
                st   <= ST_IDLE;
                pull <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR: begin
                        if (ev.rise) begin
                            sh  <= {sh[ADDR_W-2:0], ev.sda};
                            cnt <= cnt + 1'b1;
                            if (cnt == LAST_BIT) begin
                                if (addr_hit(sh, own_addr)) begin
                                    st  <= ST_ACK_WAIT;
                                    hit <= 1'b1;
                                end else begin
                                    st <= ST_IGNORE;
                                end
                            end
                        end
                    end
                    ST_ACK_WAIT: begin
                        if (ev.fall) begin
                            st   <= ST_ACK_DRV;
                            pull <= ~ack_bit;
                        end
                    end
                    ST_ACK_DRV: begin
                        if (ev.fall) begin
                            st   <= ST_IGNORE;
                            pull <= 1'b0;
                        end
                    end
                    default: pull <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_am_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             addr_wr_en,
    input  logic [REG_W-1:0] addr_wr_data,
    output logic [REG_W-1:0] addr_rd,
    input  logic             ack_bit,
    input  logic             irq_en,
    input  logic             match_clr,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_pull,
    output logic             match_flag,
    output logic             mst_clr,
    output logic             irq
);
    bus_ev_t           ev;
    logic [ADDR_W-1:0] own_addr;
    logic              hit;

    i2c_am_cond u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_am_areg u_areg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (addr_wr_en),
        .wr_data  (addr_wr_data),
        .own_addr (own_addr),
        .rd_data  (addr_rd)
    );

    i2c_am_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .ev       (ev),
        .own_addr (own_addr),
        .ack_bit  (ack_bit),
        .pull     (sda_pull),
        .hit      (hit)
    );

    // Sticky flag: a new hit wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)
            match_flag <= 1'b0;
        else if (hit)
            match_flag <= 1'b1;
        else if (match_clr)
            match_flag <= 1'b0;
    end

    assign mst_clr = hit;
    assign irq     = match_flag & irq_en;
endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       addr_wr_en,
    input logic [7:0] addr_wr_data,
    input logic [7:0] addr_rd,
    input logic       irq_en,
    input logic       match_clr,
    input logic       scl_i,
    input logic       sda_pull,
    input logic       match_flag,
    input logic       mst_clr,
    input logic       irq
);
    // R1
    a_r1_write_readback: assert property (@(posedge clk) disable iff (rst)
        addr_wr_en |=> (addr_rd == {1'b0, $past(addr_wr_data[6:0])}));

    // R5
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        mst_clr |=> !mst_clr);

    // R4
    a_r4_flag_sets: assert property (@(posedge clk) disable iff (rst)
        mst_clr |=> match_flag);

    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (match_flag && !match_clr) |=> match_flag);

    // R6
    a_r6_irq_gated: assert property (@(posedge clk) disable iff (rst)
        irq |-> irq_en);

    // R3
    a_r3_pull_in_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !scl_i);

    // R7
    a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!sda_pull && !mst_clr));
endmodule

bind i2c_addr_match i2c_addr_match_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .addr_wr_en   (addr_wr_en),
    .addr_wr_data (addr_wr_data),
    .addr_rd      (addr_rd),
    .irq_en       (irq_en),
    .match_clr    (match_clr),
    .scl_i        (scl_i),
    .sda_pull     (sda_pull),
    .match_flag   (match_flag),
    .mst_clr      (mst_clr),
    .irq          (irq)
);

// File: tb/i2c_addr_match_tb.sv
`timescale 1ns/1ps
module i2c_addr_match_tb;
    localparam int Q = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b1;
    logic       addr_wr_en = 1'b0;
    logic [7:0] addr_wr_data = '0;
    logic [7:0] addr_rd;
    logic       ack_bit = 1'b0;
    logic       irq_en = 1'b0;
    logic       match_clr = 1'b0;
    logic       scl = 1'b1;
    logic       sda_drv = 1'b1;
    logic       sda_line;
    logic       sda_pull, match_flag, mst_clr, irq;

    int n_tests = 0;
    int n_fail  = 0;
    int pulses  = 0;
    logic [6:0] cur_addr = '0;

    always #2 clk = ~clk;

    assign sda_line = sda_drv & ~sda_pull;

    i2c_addr_match u_dut (
        .clk(clk), .rst(rst), .en(en),
        .addr_wr_en(addr_wr_en), .addr_wr_data(addr_wr_data), .addr_rd(addr_rd),
        .ack_bit(ack_bit), .irq_en(irq_en), .match_clr(match_clr),
        .scl_i(scl), .sda_i(sda_line),
        .sda_pull(sda_pull), .match_flag(match_flag), .mst_clr(mst_clr), .irq(irq)
    );

    always @(negedge clk) if (mst_clr) pulses++;

    task automatic chk(input logic cond, input string req, input int act, input int exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    function automatic logic exp_hit(input logic [7:0] b, input logic [6:0] a, input logic e);
        return e && (b[7:1] == a);
    endfunction

    task automatic wr_addr(input logic [7:0] v);
        addr_wr_data = v; addr_wr_en = 1'b1; tick(1);
        addr_wr_en = 1'b0; tick(1);
        cur_addr = v[6:0];
    endtask

    task automatic clear_flag();
        match_clr = 1'b1; tick(1); match_clr = 1'b0; tick(1);
    endtask

    task automatic bit_out(input logic b);
        sda_drv = b; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_drv = 1'b0; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_drv = 1'b1; tick(Q);
    endtask

    // Address byte plus acknowledge clock; reports pull in the slot and after it.
    task automatic addr_txn(input logic [7:0] b, output logic in_slot, output logic after);
        logic p1, p2;
        bus_start();
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        sda_drv = 1'b1; tick(Q); p1 = sda_pull;
        scl = 1'b1; tick(Q); p2 = sda_pull;
        scl = 1'b0; tick(Q); after = sda_pull;
        in_slot = p1 & p2;
        if (p1 != p2) in_slot = 1'bx;
    endtask

    task automatic data_quiet(input logic [7:0] d, output logic any_pull);
        any_pull = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            sda_drv = d[i]; tick(Q); any_pull |= sda_pull;
            scl = 1'b1; tick(Q); any_pull |= sda_pull;
            scl = 1'b0; tick(Q); any_pull |= sda_pull;
        end
    endtask

    task automatic run_case(input logic [7:0] b, input logic do_data);
        logic in_slot, after, dp, eh;
        int p0;
        eh = exp_hit(b, cur_addr, en);
        p0 = pulses;
        addr_txn(b, in_slot, after);
        chk(in_slot === (eh & ~ack_bit), "R3/R8 ack slot pull", int'(in_slot), int'(eh & ~ack_bit));
        chk(after == 1'b0, "R10 release after slot", int'(after), 0);
        chk(match_flag == eh, "R2/R4/R7 match flag", int'(match_flag), int'(eh));
        chk((pulses - p0) == int'(eh), "R5 mst_clr pulse count", pulses - p0, int'(eh));
        chk(irq == (eh & irq_en), "R6 irq", int'(irq), int'(eh & irq_en));
        if (do_data) begin
            data_quiet(8'hA5 ^ b, dp);
            chk(dp == 1'b0, "R10 data byte quiet", int'(dp), 0);
        end
        bus_stop();
        if (eh) begin
            tick(5);
            chk(match_flag == 1'b1, "R4 flag sticky", int'(match_flag), 1);
            clear_flag();
            chk(match_flag == 1'b0, "R4 flag cleared", int'(match_flag), 0);
        end
    endtask

    initial begin
        logic in_slot, after;
        logic [7:0] b;
        void'($urandom(32'd1357));
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset values
        chk(addr_rd == 8'h00, "R1 reset address", addr_rd, 0);
        chk(match_flag == 0 && irq == 0 && sda_pull == 0, "R1 reset outputs", int'(match_flag), 0);
        wr_addr(8'hFF);
        chk(addr_rd == 8'h7F, "R1 bit7 reads zero", addr_rd, 8'h7F);
        wr_addr(8'h2C);
        chk(addr_rd == 8'h2C, "R1 readback", addr_rd, 8'h2C);

        // R2 both directions hit
        irq_en = 1'b1; ack_bit = 1'b0;
        run_case({7'h2C, 1'b0}, 1'b1);
        run_case({7'h2C, 1'b1}, 1'b0);
        // R3 ack_bit=1 leaves SDA released but still flags
        ack_bit = 1'b1;
        run_case({7'h2C, 1'b0}, 1'b0);
        ack_bit = 1'b0;

        // R6 irq follows enable with flag held
        addr_txn({7'h2C, 1'b1}, in_slot, after); bus_stop();
        irq_en = 1'b0; tick(1);
        chk(irq == 1'b0, "R6 irq masked", int'(irq), 0);
        irq_en = 1'b1; tick(1);
        chk(irq == 1'b1, "R6 irq unmasked", int'(irq), 1);
        clear_flag();

        // R7 disabled
        en = 1'b0;
        run_case({7'h2C, 1'b0}, 1'b0);
        en = 1'b1;

        // R8 miss then repeated START with right address
        addr_txn({7'h2D, 1'b0}, in_slot, after);
        chk(in_slot === 1'b0, "R8 miss no ack", int'(in_slot), 0);
        addr_txn({7'h2C, 1'b0}, in_slot, after);
        chk(in_slot === 1'b1, "R8 repeated start ack", int'(in_slot), 1);
        chk(match_flag == 1'b1, "R8 repeated start flag", int'(match_flag), 1);
        bus_stop(); clear_flag();

        // R9 STOP abandons partial byte
        bus_start();
        for (int i = 7; i >= 4; i--) bit_out(b[i] ^ 1'b0);
        bus_stop();
        scl = 1'b0; tick(Q);
        b = {7'h2C, 1'b0};
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        sda_drv = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        chk(sda_pull == 1'b0, "R9 no ack without start", int'(sda_pull), 0);
        scl = 1'b0; tick(Q);
        chk(match_flag == 1'b0, "R9 no flag without start", int'(match_flag), 0);
        scl = 1'b1; tick(Q); sda_drv = 1'b0; tick(Q); sda_drv = 1'b1; tick(Q);

        // Random mix
        for (int k = 0; k < 40; k++) begin
            wr_addr(8'($urandom));
            b = 8'($urandom);
            if ($urandom % 2) b[7:1] = cur_addr;
            ack_bit = 1'($urandom);
            irq_en  = 1'($urandom);
            en      = ($urandom % 6) != 0;
            run_case(b, 1'($urandom));
            if (match_flag) clear_flag();
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #800000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule